// File: doc/BRIEF.md
# Configurable Logic Cell with Run-Time Register Type

This block is one logic cell of a programmable fabric. It receives four sum-of-products results, called A, B, C and D, plus a set of static configuration inputs. The configuration gives each sum a job. A sum can feed the storage element as data, as a control such as clock, preset or reset, or as an output enable. It can also pass straight through as a combinational result. The single storage bit can act as a D, T or JK flip-flop. It can also act as a D/T hybrid, where a shared type-switch line picks D or T while the fabric runs. That lets a counter load in D mode and count in T mode.

All sequential logic runs on the fabric clock `clk`. The selected register clock is sampled on that clock, and one of its active edges becomes a one-cycle update strobe. Presets and resets act at once, with no clock needed. Each one overrides the visible register value in the cycle it is raised, and the register then keeps the forced value. The cell drives two selectable outputs, an output-enable line and a feedback line.

Top module: `logic_cell`

## Requirements
- R1: With `a_role_i`=0, sum A feeds the register data input: D in D mode, T in T mode, J in JK mode. Selecting A on an output then reads 0. With `a_role_i`=1, A is a combinational result and the register data input reads 0.
- R2: `b_role_i` sets the role of sum B: 0 = K input, 1 = active-high preset, 2 = combinational. In roles 0 and 1, an output that selects B reads 0. The preset forces the visible Q to 1 in the same cycle it is raised.
- R3: `c_role_i` sets the role of sum C: 0 = register clock (rising edge), 1 = active-high reset, 2 = combinational. The reset forces the visible Q to 0 in the same cycle it is raised.
- R4: `d_role_i` sets the role of sum D: 0 = register clock (rising edge), 1 = drives `oe_o`, 2 = drives `fb_o`. When D is not in role 1, `oe_o` is 1. When D is not in role 2, `fb_o` is 0.
- R5: The clock source is chosen in priority order: sum C if it is in the clock role, otherwise sum D if it is in the clock role, otherwise `gclk_i` XOR `gclk_inv_i`. When the source rises between two `clk` edges, Q takes its new value at the next `clk` edge. With no such edge, Q holds.
- R6: `reg_kind_i`=0 selects D mode: Q takes the data input.
- R7: `reg_kind_i`=1 selects T mode: Q toggles when the data input is 1 and holds when it is 0.
- R8: `reg_kind_i`=2 selects JK mode, with J = data input and K = the K role of sum B. J/K of 1/1 toggles Q, 0/0 holds, 1/0 sets Q, and 0/1 clears Q.
- R9: `reg_kind_i`=3 selects D/T switching: D mode while `gtype_d_i` is 1, T mode while it is 0.
- R10: `gpreset_i` and `greset_i` act like the sum preset and reset, with no clock needed. When any reset and any preset are active together, Q is 0. After release, Q keeps the forced value.
- R11: Each output `sel_o[i]` uses the 2-bit field `out_sel_i[2i+1:2i]` to pick its source: 0 = Q, 1 = A, 2 = B, 3 = C.
- R12: While `rst_n` is low, Q is 0. In the first `clk` cycle after release, no clock edge is taken, even if the source is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; samples the register clock source |
| rst_n | input | 1 | Active-low fabric reset |
| sum_i | input | 4 | Sum results: bit 0 = A, 1 = B, 2 = C, 3 = D |
| gclk_i | input | 1 | Shared high-speed register clock |
| gclk_inv_i | input | 1 | Inverts the shared clock before edge detection |
| gpreset_i | input | 1 | Shared asynchronous preset |
| greset_i | input | 1 | Shared asynchronous reset |
| gtype_d_i | input | 1 | Shared type switch: 1 = D, 0 = T (kind 3 only) |
| a_role_i | input | 1 | Role of sum A |
| b_role_i | input | 2 | Role of sum B |
| c_role_i | input | 2 | Role of sum C |
| d_role_i | input | 2 | Role of sum D |
| reg_kind_i | input | 2 | Register type |
| out_sel_i | input | 2*N_SEL_OUT | Source select per selectable output |
| sel_o | output | N_SEL_OUT | Selectable outputs |
| oe_o | output | 1 | Output enable for the attached I/O |
| fb_o | output | 1 | Buried feedback result |

## Verification
Combinational results are due 0 cycles after a stimulus: sum pass-through, output selection, output enable, feedback, and the forced Q from a preset or reset. Register updates are due 1 cycle after the active edge of the clock source. The bench drives inputs on the falling edge of `clk`. It checks combinational results 2 ns later, before the next rising edge. For a clock pulse, it raises the source on one falling edge and lowers it on the next, then checks Q after that. That point comes after exactly one rising edge that could have taken the update. Hold cases are checked the same way, after cycles that contain no source edge.

// File: rtl/lc_pkg.sv
package lc_pkg;

   typedef enum logic [0:0] {A_TO_REG = 1'b0, A_TO_COMB = 1'b1} a_role_e;
   typedef enum logic [1:0] {B_TO_K = 2'd0, B_TO_PRESET = 2'd1, B_TO_COMB = 2'd2} b_role_e;
   typedef enum logic [1:0] {C_TO_CLOCK = 2'd0, C_TO_RESET = 2'd1, C_TO_COMB = 2'd2} c_role_e;
   typedef enum logic [1:0] {D_TO_CLOCK = 2'd0, D_TO_OE = 2'd1, D_TO_FBK = 2'd2} d_role_e;
   typedef enum logic [1:0] {KIND_D = 2'd0, KIND_T = 2'd1, KIND_JK = 2'd2, KIND_DT = 2'd3} kind_e;
   typedef enum logic [1:0] {SEL_Q = 2'd0, SEL_A = 2'd1, SEL_B = 2'd2, SEL_C = 2'd3} sel_e;
   typedef enum logic [1:0] {SRC_GLOBAL = 2'd0, SRC_SUM_C = 2'd1, SRC_SUM_D = 2'd2} src_e;

   localparam int SUM_COUNT = 4;
   localparam int SUM_A = 0;
   localparam int SUM_B = 1;
   localparam int SUM_C = 2;
   localparam int SUM_D = 3;
   localparam int SEL_W = 2;

   typedef struct packed {
      logic reg_data;
      logic reg_k;
      logic set_req;
      logic clr_req;
      logic view_a;
      logic view_b;
      logic view_c;
   } route_t;

endpackage

// File: rtl/lc_route.sv
module lc_route
   import lc_pkg::*;
#(
   parameter logic OE_IDLE  = 1'b1,
   parameter logic FBK_IDLE = 1'b0
) (
   input  logic [SUM_COUNT-1:0] sum_i,
   input  a_role_e              a_role_i,
   input  b_role_e              b_role_i,
   input  c_role_e              c_role_i,
   input  d_role_e              d_role_i,
   output route_t               route_o,
   output src_e                 src_o,
   output logic                 oe_o,
   output logic                 fb_o
);

   logic a_s, b_s, c_s, d_s;

   assign a_s = sum_i[SUM_A];
   assign b_s = sum_i[SUM_B];
   assign c_s = sum_i[SUM_C];
   assign d_s = sum_i[SUM_D];

   always_comb begin
      route_o.reg_data = (a_role_i == A_TO_REG)    ? a_s : 1'b0;
      route_o.view_a   = (a_role_i == A_TO_COMB)   ? a_s : 1'b0;
      route_o.reg_k    = (b_role_i == B_TO_K)      ? b_s : 1'b0;
      route_o.set_req  = (b_role_i == B_TO_PRESET) ? b_s : 1'b0;
      route_o.view_b   = (b_role_i == B_TO_COMB)   ? b_s : 1'b0;
      route_o.clr_req  = (c_role_i == C_TO_RESET)  ? c_s : 1'b0;
      route_o.view_c   = (c_role_i == C_TO_COMB)   ? c_s : 1'b0;
   end

   always_comb begin
      if (c_role_i == C_TO_CLOCK)      src_o = SRC_SUM_C;
      else if (d_role_i == D_TO_CLOCK) src_o = SRC_SUM_D;
      else                             src_o = SRC_GLOBAL;
   end

   assign oe_o = (d_role_i == D_TO_OE)  ? d_s : OE_IDLE;
   assign fb_o = (d_role_i == D_TO_FBK) ? d_s : FBK_IDLE;

endmodule

// File: rtl/lc_clksel.sv
module lc_clksel
   import lc_pkg::*;
#(
   parameter bit GCLK_INV_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  src_e src_i,
   input  logic gclk_i,
   input  logic gclk_inv_i,
   input  logic sum_c_i,
   input  logic sum_d_i,
   output logic edge_o
);

   logic gclk_pol;
   logic src_now;
   logic src_q;
   logic armed_q;

   generate
      if (GCLK_INV_EN) begin : g_pol
         assign gclk_pol = gclk_i ^ gclk_inv_i;
      end else begin : g_nopol
         logic unused_inv;
         assign unused_inv = gclk_inv_i;
         assign gclk_pol   = gclk_i;
      end
   endgenerate

   always_comb begin
      unique case (src_i)
         SRC_SUM_C: src_now = sum_c_i;
         SRC_SUM_D: src_now = sum_d_i;
         default:   src_now = gclk_pol;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q   <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         src_q   <= src_now;
         armed_q <= 1'b1;
      end
   end

   assign edge_o = armed_q & src_now & ~src_q;

   assert_edge_spaced_R5: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o);

endmodule

// File: rtl/lc_store.sv
module lc_store
   import lc_pkg::*;
#(
   parameter logic RESET_Q = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  edge_i,
   input  kind_e kind_i,
   input  logic  gtype_d_i,
   input  logic  data_i,
   input  logic  k_i,
   input  logic  set_i,
   input  logic  clr_i,
   output logic  q_o
);

   kind_e mode;
   logic  q_reg;
   logic  q_next;

   always_comb begin
      if (kind_i == KIND_DT) mode = gtype_d_i ? KIND_D : KIND_T;
      else                   mode = kind_i;
   end

   always_comb begin
      unique case (mode)
         KIND_T:  q_next = q_reg ^ data_i;
         KIND_JK: begin
            unique case ({data_i, k_i})
               2'b00:   q_next = q_reg;
               2'b01:   q_next = 1'b0;
               2'b10:   q_next = 1'b1;
               default: q_next = ~q_reg;
            endcase
         end
         default: q_next = data_i;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_reg <= RESET_Q;
      else if (clr_i)  q_reg <= 1'b0;
      else if (set_i)  q_reg <= 1'b1;
      else if (edge_i) q_reg <= q_next;
   end

   assign q_o = clr_i ? 1'b0 : (set_i ? 1'b1 : q_reg);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_i && !set_i && !clr_i) |=> (q_reg == $past(q_reg)));

   assert_t_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i && !set_i && !clr_i && mode == KIND_T && data_i) |=> (q_reg != $past(q_reg)));

   assert_jk_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i && !set_i && !clr_i && mode == KIND_JK && data_i && !k_i) |=> q_reg);

   assert_reset_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !q_reg);

endmodule

// File: rtl/lc_outmux.sv
module lc_outmux
   import lc_pkg::*;
#(
   parameter int N_SEL = 2
) (
   input  logic                   q_i,
   input  logic                   view_a_i,
   input  logic                   view_b_i,
   input  logic                   view_c_i,
   input  logic [SEL_W*N_SEL-1:0] sel_i,
   output logic [N_SEL-1:0]       out_o
);

   generate
      for (genvar gi = 0; gi < N_SEL; gi++) begin : g_out
         sel_e pick;
         assign pick = sel_e'(sel_i[SEL_W*gi +: SEL_W]);
         always_comb begin
            unique case (pick)
               SEL_A:   out_o[gi] = view_a_i;
               SEL_B:   out_o[gi] = view_b_i;
               SEL_C:   out_o[gi] = view_c_i;
               default: out_o[gi] = q_i;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/logic_cell.sv
module logic_cell
   import lc_pkg::*;
#(
   parameter int   N_SEL_OUT   = 2,
   parameter bit   GCLK_INV_EN = 1'b1,
   parameter logic OE_IDLE     = 1'b1,
   parameter logic RESET_Q     = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [3:0]                 sum_i,
   input  logic                       gclk_i,
   input  logic                       gclk_inv_i,
   input  logic                       gpreset_i,
   input  logic                       greset_i,
   input  logic                       gtype_d_i,
   input  logic [0:0]                 a_role_i,
   input  logic [1:0]                 b_role_i,
   input  logic [1:0]                 c_role_i,
   input  logic [1:0]                 d_role_i,
   input  logic [1:0]                 reg_kind_i,
   input  logic [2*N_SEL_OUT-1:0]     out_sel_i,
   output logic [N_SEL_OUT-1:0]       sel_o,
   output logic                       oe_o,
   output logic                       fb_o
);

   localparam int SEL_BITS = SEL_W * N_SEL_OUT;

   generate
      if (N_SEL_OUT < 1 || N_SEL_OUT > 2) begin : g_bad_count
         $error("logic_cell: N_SEL_OUT must be 1 or 2");
      end
      if (SEL_BITS != 2 * N_SEL_OUT) begin : g_bad_width
         $error("logic_cell: select field width mismatch");
      end
   endgenerate

   route_t rt;
   src_e   src;
   logic   clk_edge;
   logic   cell_q;
   logic   set_any;
   logic   clr_any;

   lc_route #(.OE_IDLE(OE_IDLE), .FBK_IDLE(1'b0)) u_route (
      .sum_i    (sum_i),
      .a_role_i (a_role_e'(a_role_i)),
      .b_role_i (b_role_e'(b_role_i)),
      .c_role_i (c_role_e'(c_role_i)),
      .d_role_i (d_role_e'(d_role_i)),
      .route_o  (rt),
      .src_o    (src),
      .oe_o     (oe_o),
      .fb_o     (fb_o)
   );

   lc_clksel #(.GCLK_INV_EN(GCLK_INV_EN)) u_clksel (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src),
      .gclk_i     (gclk_i),
      .gclk_inv_i (gclk_inv_i),
      .sum_c_i    (sum_i[SUM_C]),
      .sum_d_i    (sum_i[SUM_D]),
      .edge_o     (clk_edge)
   );

   assign set_any = gpreset_i | rt.set_req;
   assign clr_any = greset_i  | rt.clr_req;

   lc_store #(.RESET_Q(RESET_Q)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_i    (clk_edge),
      .kind_i    (kind_e'(reg_kind_i)),
      .gtype_d_i (gtype_d_i),
      .data_i    (rt.reg_data),
      .k_i       (rt.reg_k),
      .set_i     (set_any),
      .clr_i     (clr_any),
      .q_o       (cell_q)
   );

   lc_outmux #(.N_SEL(N_SEL_OUT)) u_outmux (
      .q_i      (cell_q),
      .view_a_i (rt.view_a),
      .view_b_i (rt.view_b),
      .view_c_i (rt.view_c),
      .sel_i    (out_sel_i),
      .out_o    (sel_o)
   );

   assert_oe_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (d_role_i != D_TO_OE) |-> oe_o);

   assert_greset_q_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (greset_i && out_sel_i[1:0] == SEL_Q) |-> !sel_o[0]);

   assert_a_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (a_role_i == A_TO_REG && out_sel_i[1:0] == SEL_A) |-> !sel_o[0]);

   assert_preset_q_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (gpreset_i && !clr_any && out_sel_i[1:0] == SEL_Q) |-> sel_o[0]);

endmodule

// File: tb/tb_logic_cell.sv
`timescale 1ns/1ps
module tb_logic_cell;

   localparam int NS = 2;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [3:0]      sum;
   logic            gclk, ginv, gpre, grst, gtype;
   logic [0:0]      a_role;
   logic [1:0]      b_role, c_role, d_role, kind;
   logic [2*NS-1:0] osel;
   logic [NS-1:0]   sel;
   logic            oe, fb;

   always #10 clk = ~clk;

   logic_cell #(.N_SEL_OUT(NS)) dut (
      .clk(clk), .rst_n(rst_n), .sum_i(sum), .gclk_i(gclk), .gclk_inv_i(ginv),
      .gpreset_i(gpre), .greset_i(grst), .gtype_d_i(gtype),
      .a_role_i(a_role), .b_role_i(b_role), .c_role_i(c_role), .d_role_i(d_role),
      .reg_kind_i(kind), .out_sel_i(osel), .sel_o(sel), .oe_o(oe), .fb_o(fb)
   );

   typedef struct {
      string req;
      int    sig;
      logic  exp;
   } item_t;

   item_t queue_q[$];
   event  chk_ev;
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 0;

   function automatic logic observe(int s);
      case (s)
         0: return sel[0];
         1: return sel[1];
         2: return oe;
         default: return fb;
      endcase
   endfunction

   initial begin
      forever begin
         @(chk_ev);
         while (queue_q.size() > 0) begin
            item_t it;
            logic  act;
            it  = queue_q.pop_front();
            act = observe(it.sig);
            checks++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s sig%0d actual=%b expected=%b t=%0t", it.req, it.sig, act, it.exp, $time);
            end
         end
      end
   end

   task automatic expect_v(string req, int s, logic e);
      item_t it;
      it.req = req; it.sig = s; it.exp = e;
      queue_q.push_back(it);
   endtask

   task automatic flush();
      -> chk_ev;
      #1;
   endtask

   task automatic nx();
      @(negedge clk);
   endtask

   task automatic settle();
      #2;
   endtask

   task automatic pulse_g();
      nx(); gclk = 1'b1;
      nx(); gclk = 1'b0;
      settle();
   endtask

   task automatic pulse_sum(int b);
      nx(); sum[b] = 1'b1;
      nx(); sum[b] = 1'b0;
      settle();
   endtask

   initial begin
      #(20 * 20000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; sum = 4'b0000; gclk = 1'b0; ginv = 1'b0; gpre = 1'b0; grst = 1'b0;
      gtype = 1'b0; a_role = 1'b0; b_role = 2'd2; c_role = 2'd2; d_role = 2'd2;
      kind = 2'd0; osel = 4'b1000;
      repeat (3) nx();
      settle();
      expect_v("R12 reset q", 0, 1'b0);
      expect_v("R4 oe idle", 2, 1'b1);
      expect_v("R4 fb follows D", 3, 1'b0);
      flush();
      nx(); rst_n = 1'b1;

      // R6 D mode on the shared clock
      nx(); sum[0] = 1'b1;
      pulse_g(); expect_v("R6 load 1", 0, 1'b1); flush();
      nx(); sum[0] = 1'b0;
      pulse_g(); expect_v("R6 load 0", 0, 1'b0); flush();
      // R5 no edge means hold
      nx(); sum[0] = 1'b1;
      nx(); nx(); settle();
      expect_v("R5 hold without edge", 0, 1'b0); flush();
      pulse_g(); expect_v("R5 rising shared clock", 0, 1'b1); flush();

      // R5 inverted shared clock
      nx(); sum[0] = 1'b0; gclk = 1'b1;
      nx(); ginv = 1'b1;
      settle(); expect_v("R5 load before invert", 0, 1'b0); flush();
      nx(); sum[0] = 1'b1;
      nx(); gclk = 1'b0;
      nx(); settle(); expect_v("R5 falling clock with invert", 0, 1'b1); flush();
      nx(); sum[0] = 1'b0; gclk = 1'b1;
      nx(); settle(); expect_v("R5 rising ignored with invert", 0, 1'b1); flush();
      nx(); ginv = 1'b0;
      nx(); gclk = 1'b0;
      settle(); expect_v("R5 restore polarity", 0, 1'b0); flush();

      // R7 T mode
      nx(); kind = 2'd1; sum[0] = 1'b1;
      pulse_g(); expect_v("R7 toggle 1", 0, 1'b1); flush();
      pulse_g(); expect_v("R7 toggle 2", 0, 1'b0); flush();
      pulse_g(); expect_v("R7 toggle 3", 0, 1'b1); flush();
      nx(); sum[0] = 1'b0;
      pulse_g(); expect_v("R7 hold T=0", 0, 1'b1); flush();

      // R8 JK mode, K on sum B
      nx(); kind = 2'd2; b_role = 2'd0; sum = 4'b0010;
      pulse_g(); expect_v("R8 J0K1 clear", 0, 1'b0); flush();
      nx(); sum = 4'b0001;
      pulse_g(); expect_v("R8 J1K0 set", 0, 1'b1); flush();
      nx(); sum = 4'b0000;
      pulse_g(); expect_v("R8 J0K0 hold", 0, 1'b1); flush();
      nx(); sum = 4'b0011;
      pulse_g(); expect_v("R8 J1K1 toggle", 0, 1'b0);
      expect_v("R2 B in K role reads 0", 1, 1'b0); flush();
      pulse_g(); expect_v("R8 J1K1 toggle again", 0, 1'b1); flush();

      // R9 D/T switching
      nx(); kind = 2'd3; gtype = 1'b1; b_role = 2'd2; sum = 4'b0000;
      pulse_g(); expect_v("R9 D load 0", 0, 1'b0); flush();
      nx(); sum = 4'b0001;
      pulse_g(); expect_v("R9 D load 1", 0, 1'b1); flush();
      nx(); gtype = 1'b0;
      pulse_g(); expect_v("R9 T toggle", 0, 1'b0); flush();
      pulse_g(); expect_v("R9 T toggle again", 0, 1'b1); flush();

      // R10 shared preset and reset
      nx(); kind = 2'd0; sum = 4'b0000; grst = 1'b1;
      settle(); expect_v("R10 reset immediate", 0, 1'b0); flush();
      nx(); grst = 1'b0;
      settle(); expect_v("R10 reset retained", 0, 1'b0); flush();
      nx(); gpre = 1'b1;
      settle(); expect_v("R10 preset immediate", 0, 1'b1); flush();
      nx(); grst = 1'b1;
      settle(); expect_v("R10 reset wins", 0, 1'b0); flush();
      nx(); gpre = 1'b0; grst = 1'b0;
      settle(); expect_v("R10 after both", 0, 1'b0); flush();

      // R2 sum B as preset
      nx(); b_role = 2'd1; sum = 4'b0010;
      settle(); expect_v("R2 B preset", 0, 1'b1);
      expect_v("R2 B view masked", 1, 1'b0); flush();
      nx(); sum = 4'b0000;
      settle(); expect_v("R2 preset retained", 0, 1'b1); flush();

      // R3 sum C as reset
      nx(); c_role = 2'd1; sum = 4'b0100;
      settle(); expect_v("R3 C reset", 0, 1'b0); flush();
      nx(); sum = 4'b0110;
      settle(); expect_v("R10 C reset beats B preset", 0, 1'b0); flush();
      nx(); sum = 4'b0000; b_role = 2'd2; c_role = 2'd2;
      settle(); expect_v("R10 retained 0", 0, 1'b0); flush();

      // R3 sum C as clock, shared clock ignored
      nx(); c_role = 2'd0; sum = 4'b0001;
      pulse_sum(2); expect_v("R3 C clock loads", 0, 1'b1); flush();
      nx(); sum[0] = 1'b0;
      pulse_g(); expect_v("R5 shared clock ignored", 0, 1'b1); flush();

      // R4 sum D as clock, oe, feedback
      nx(); c_role = 2'd2; d_role = 2'd0;
      pulse_sum(3); expect_v("R4 D clock loads", 0, 1'b0);
      expect_v("R4 oe idle with D clock", 2, 1'b1);
      expect_v("R4 fb idle with D clock", 3, 1'b0); flush();
      nx(); sum[0] = 1'b1;
      pulse_sum(3); expect_v("R4 D clock loads 1", 0, 1'b1); flush();
      nx(); d_role = 2'd1; sum = 4'b0000;
      settle(); expect_v("R4 oe low", 2, 1'b0); expect_v("R4 fb idle", 3, 1'b0); flush();
      nx(); sum = 4'b1000;
      settle(); expect_v("R4 oe high", 2, 1'b1); flush();
      nx(); d_role = 2'd2;
      settle(); expect_v("R4 fb high", 3, 1'b1); expect_v("R4 oe idle", 2, 1'b1); flush();

      // R11 and R1 combinational selection
      nx(); sum = 4'b0101; a_role = 1'b1; osel = 4'b1101;
      settle(); expect_v("R1 A comb", 0, 1'b1); expect_v("R11 C view", 1, 1'b1); flush();
      nx(); sum = 4'b0100;
      settle(); expect_v("R11 A view 0", 0, 1'b0); expect_v("R11 C view 1", 1, 1'b1); flush();
      nx(); sum = 4'b0001;
      settle(); expect_v("R11 A view 1", 0, 1'b1); expect_v("R11 C view 0", 1, 1'b0); flush();
      nx(); osel = 4'b0001;
      pulse_g(); expect_v("R1 data input 0 when A comb", 1, 1'b0);
      expect_v("R1 A view", 0, 1'b1); flush();
      nx(); a_role = 1'b0;
      settle(); expect_v("R1 A view masked", 0, 1'b0); flush();
      nx(); osel = 4'b0010; sum = 4'b0010;
      settle(); expect_v("R11 B view", 0, 1'b1); flush();

      // R12 source already high at reset release
      nx(); rst_n = 1'b0; osel = 4'b0000; gclk = 1'b1; sum = 4'b0001;
      nx(); nx(); settle(); expect_v("R12 reset clears", 0, 1'b0); flush();
      nx(); rst_n = 1'b1;
      nx(); nx(); settle(); expect_v("R12 first cycle edge ignored", 0, 1'b0); flush();
      nx(); gclk = 1'b0;
      pulse_g(); expect_v("R12 later edge taken", 0, 1'b1); flush();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule